// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Alarm

This core keeps wall-clock time as packed BCD bytes: seconds, minutes, hours, day of month, month (1 to 12), two-digit year (0 to 99) and a weekday counter (0 to 6). A one-second tick input advances the count when the run bit is set. A byte-wide register bus gives access to the time fields, six alarm fields, a control byte and a few plain storage bytes. The bus has an address, a write enable, write data and combinational read data.

Reads of the time fields always return a captured copy of the live count. Software writes the control byte with the capture bit set, then reads the seven time bytes in any order and gets a coherent set, even if a tick lands in between. To set the clock, software clears the run bit, writes the time bytes and sets the run bit again. On every counted tick the core compares the new time against the alarm fields and pulses a one-cycle match strobe when all six fields agree.

Top module: `rtc_core`

## Requirements
- R1: After reset the time bytes read as seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. The control byte reads 0x00 and alarm_match is 0.
- R2: The register map is fixed. Addresses 0x00 to 0x06 hold seconds, minutes, hours, day, month, year and weekday. Addresses 0x07 to 0x0C hold the alarm fields in the same order from seconds to year. 0x0D is control, 0x0E status, 0x0F interrupt enable, 0x10 compensation low byte and 0x11 compensation high byte. Alarm, status, interrupt enable and compensation bytes read back what was written. Control bits 0 to 5 read back what was written. Any address above 0x11 reads 0x00.
- R3: Control bit 0 is the run bit. A tick advances the time only while this bit is 1. While it is 0, ticks leave every time field unchanged.
- R4: A control write with bit 6 set copies all seven live time fields into the read copy on that clock edge. Time reads return that copy until the next capture. Control bit 6 always reads 0.
- R5: A write to a time address loads the live field on that clock edge. A tick that arrives in the same cycle as any time write is discarded.
- R6: Seconds and minutes go from 0x59 to 0x00 and carry into the next field. Hours go from 0x23 to 0x00 and carry into the day.
- R7: The day goes from the last day of the month to 0x01. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R8: The month goes from 0x12 to 0x01 and carries into the year. The year goes from 0x99 to 0x00.
- R9: The weekday goes up by one each time the day advances, and wraps from 0x06 to 0x00.
- R10: alarm_match is high for exactly one cycle after a clock edge where a counted tick makes seconds through year equal the six alarm fields. The weekday takes no part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Register write enable |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Combinational read data for addr |
| alarm_match | output | 1 | One-cycle alarm strobe |

## Verification
The embedded assertions check the following on every cycle:
- ticks leave the live time frozen while halted;
- a capture copies the live count exactly;
- seconds wrap correctly;
- the month wraps correctly;
- the weekday moves whenever the day rolls;
- the match strobe never lasts two cycles;
- run-bit and alarm writes land in storage.

Only the bench scenarios show the rest:
- the full calendar arithmetic: month lengths, leap Februaries and the century wrap;
- that a stale copy really persists on the bus;
- that a tick coinciding with a time write is lost;
- that a partial alarm match stays silent.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_TIME   = 7;   // sec, min, hour, day, month, year, weekday
  localparam int NUM_FIELD  = 6;   // fields taking part in alarm compare
  localparam int ALARM_BASE = 7;
  localparam int CTRL_ADDR  = 13;
  localparam int STAT_ADDR  = 14;
  localparam int INTEN_ADDR = 15;
  localparam int COMPL_ADDR = 16;
  localparam int COMPH_ADDR = 17;
  localparam int RUN_BIT    = 0;
  localparam int SNAP_BIT   = 6;
  localparam int CTRL_KEEP  = 6;   // stored control bits [5:0]

  localparam int F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DAY = 3,
                 F_MON = 4, F_YEAR = 5, F_WDAY = 6;

  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    logic                 advance;
    logic                 capture;
    logic [NUM_TIME-1:0]  timeWr;
    logic [NUM_FIELD-1:0] alarmWr;
    byte_t                wrData;
  } rtcStrobe_t;

  function automatic byte_t bcdInc(byte_t v);
    byte_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic byte_t monthLast(byte_t mon, byte_t yr);
    logic [7:0] yrBin;
    byte_t      r;
    yrBin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    case (mon)
      8'h02:                      r = (yrBin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_en,
  input  byte_t                       wr_data,
  input  logic [NUM_TIME-1:0][7:0]    shadowRegs,
  input  logic [NUM_FIELD-1:0][7:0]   alarmRegs,
  output rtcStrobe_t                  str,
  output byte_t                       rd_data
);
  logic [CTRL_KEEP-1:0] ctrlQ;
  byte_t statusQ, intEnQ, compLoQ, compHiQ;
  logic [NUM_TIME-1:0]  timeHit;
  logic [NUM_FIELD-1:0] alarmHit;
  logic ctrlHit, statHit, intEnHit, compLoHit, compHiHit;

  assign ctrlHit   = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign statHit   = wr_en && (addr == ADDR_W'(STAT_ADDR));
  assign intEnHit  = wr_en && (addr == ADDR_W'(INTEN_ADDR));
  assign compLoHit = wr_en && (addr == ADDR_W'(COMPL_ADDR));
  assign compHiHit = wr_en && (addr == ADDR_W'(COMPH_ADDR));

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_timeDec
    assign timeHit[i] = wr_en && (addr == ADDR_W'(i));
  end
  for (genvar i = 0; i < NUM_FIELD; i++) begin : g_alarmDec
    assign alarmHit[i] = wr_en && (addr == ADDR_W'(ALARM_BASE + i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlQ   <= '0;
      statusQ <= '0;
      intEnQ  <= '0;
      compLoQ <= '0;
      compHiQ <= '0;
    end else begin
      if (ctrlHit)   ctrlQ   <= wr_data[CTRL_KEEP-1:0];
      if (statHit)   statusQ <= wr_data;
      if (intEnHit)  intEnQ  <= wr_data;
      if (compLoHit) compLoQ <= wr_data;
      if (compHiHit) compHiQ <= wr_data;
    end
  end

  always_comb begin
    str.timeWr  = timeHit;
    str.alarmWr = alarmHit;
    str.wrData  = wr_data;
    str.capture = ctrlHit && wr_data[SNAP_BIT];
    str.advance = tick && ctrlQ[RUN_BIT] && (timeHit == '0);
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_TIME; i++)
      if (addr == ADDR_W'(i)) rd_data = shadowRegs[i];
    for (int i = 0; i < NUM_FIELD; i++)
      if (addr == ADDR_W'(ALARM_BASE + i)) rd_data = alarmRegs[i];
    if (addr == ADDR_W'(CTRL_ADDR))  rd_data = {{(DATA_W-CTRL_KEEP){1'b0}}, ctrlQ};
    if (addr == ADDR_W'(STAT_ADDR))  rd_data = statusQ;
    if (addr == ADDR_W'(INTEN_ADDR)) rd_data = intEnQ;
    if (addr == ADDR_W'(COMPL_ADDR)) rd_data = compLoQ;
    if (addr == ADDR_W'(COMPH_ADDR)) rd_data = compHiQ;
  end

  AST_RUN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlHit |=> (ctrlQ[RUN_BIT] == $past(wr_data[RUN_BIT]))); // R3
  AST_ALARM_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    alarmHit[0] |=> (alarmRegs[0] == $past(wr_data))); // R2
endmodule

// File: rtl/rtc_datapath.sv
`timescale 1ns/1ps
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  rtcStrobe_t                 str,
  output logic [NUM_TIME-1:0][7:0]   shadowRegs,
  output logic [NUM_FIELD-1:0][7:0]  alarmRegs,
  output logic                       alarmMatch
);
  localparam logic [NUM_TIME-1:0][7:0] TIME_RST =
    {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [NUM_TIME-1:0][7:0]  liveQ;
  logic [NUM_TIME-1:0][7:0]  tickNext;
  logic [NUM_TIME-1:0]       adv;
  logic [NUM_FIELD-1:0][7:0] tickResult;
  logic [NUM_FIELD-1:0]      fieldEq;
  logic secWrap, minWrap, hrWrap, dayWrap, monWrap;
  byte_t dayTop;
  logic matchQ;

  // carry chain
  always_comb begin
    dayTop  = monthLast(liveQ[F_MON], liveQ[F_YEAR]);
    secWrap = (liveQ[F_SEC] == 8'h59);
    minWrap = secWrap && (liveQ[F_MIN] == 8'h59);
    hrWrap  = minWrap && (liveQ[F_HOUR] == 8'h23);
    dayWrap = hrWrap && (liveQ[F_DAY] == dayTop);
    monWrap = dayWrap && (liveQ[F_MON] == 8'h12);
    adv[F_SEC]  = 1'b1;
    adv[F_MIN]  = secWrap;
    adv[F_HOUR] = minWrap;
    adv[F_DAY]  = hrWrap;
    adv[F_MON]  = dayWrap;
    adv[F_YEAR] = monWrap;
    adv[F_WDAY] = hrWrap;
  end

  // per-field successor values
  always_comb begin
    tickNext[F_SEC]  = (liveQ[F_SEC]  == 8'h59) ? 8'h00 : bcdInc(liveQ[F_SEC]);
    tickNext[F_MIN]  = (liveQ[F_MIN]  == 8'h59) ? 8'h00 : bcdInc(liveQ[F_MIN]);
    tickNext[F_HOUR] = (liveQ[F_HOUR] == 8'h23) ? 8'h00 : bcdInc(liveQ[F_HOUR]);
    tickNext[F_DAY]  = (liveQ[F_DAY]  == dayTop) ? 8'h01 : bcdInc(liveQ[F_DAY]);
    tickNext[F_MON]  = (liveQ[F_MON]  == 8'h12) ? 8'h01 : bcdInc(liveQ[F_MON]);
    tickNext[F_YEAR] = (liveQ[F_YEAR] == 8'h99) ? 8'h00 : bcdInc(liveQ[F_YEAR]);
    tickNext[F_WDAY] = (liveQ[F_WDAY] >= 8'h06) ? 8'h00 : liveQ[F_WDAY] + 8'h01;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      liveQ <= TIME_RST;
    end else begin
      for (int i = 0; i < NUM_TIME; i++) begin
        if (str.timeWr[i])               liveQ[i] <= str.wrData;
        else if (str.advance && adv[i])  liveQ[i] <= tickNext[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           shadowRegs <= TIME_RST;
    else if (str.capture) shadowRegs <= liveQ;
  end

  for (genvar i = 0; i < NUM_FIELD; i++) begin : g_alarm
    always_ff @(posedge clk) begin
      if (!rst_n)              alarmRegs[i] <= 8'h00;
      else if (str.alarmWr[i]) alarmRegs[i] <= str.wrData;
    end
    assign tickResult[i] = adv[i] ? tickNext[i] : liveQ[i];
    assign fieldEq[i]    = (tickResult[i] == alarmRegs[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) matchQ <= 1'b0;
    else        matchQ <= str.advance && (&fieldEq);
  end
  assign alarmMatch = matchQ;

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!str.advance && (str.timeWr == '0)) |=> $stable(liveQ)); // R3
  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    str.capture |=> (shadowRegs == $past(liveQ))); // R4
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (str.advance && (liveQ[F_SEC] == 8'h59)) |=> (liveQ[F_SEC] == 8'h00)); // R6
  AST_MONTH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (str.advance && dayWrap && (liveQ[F_MON] == 8'h12)) |=> (liveQ[F_MON] == 8'h01)); // R8
  AST_WDAY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (str.advance && hrWrap) |=> (liveQ[F_WDAY] != $past(liveQ[F_WDAY]))); // R9
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    alarmMatch |=> !alarmMatch); // R10
endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              alarm_match
);
  rtcStrobe_t                str;
  logic [NUM_TIME-1:0][7:0]  shadowRegs;
  logic [NUM_FIELD-1:0][7:0] alarmRegs;

  rtc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .shadowRegs (shadowRegs),
    .alarmRegs  (alarmRegs),
    .str        (str),
    .rd_data    (rd_data)
  );

  rtc_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .str        (str),
    .shadowRegs (shadowRegs),
    .alarmRegs  (alarmRegs),
    .alarmMatch (alarm_match)
  );
endmodule

// File: tb/rtc_core_tb.sv
`timescale 1ns/1ps
module rtc_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       alarm_match;

  int checks = 0;
  int errors = 0;
  int runBit = 0;
  int eS, eM, eH, eD, eMo, eY, eW;
  int matchSeen;

  always #10 clk = ~clk;

  rtc_core #(.ADDR_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .alarm_match(alarm_match)
  );

  function automatic int toBcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int daysIn(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int expField(int i);
    case (i)
      0: return toBcd(eS);
      1: return toBcd(eM);
      2: return toBcd(eH);
      3: return toBcd(eD);
      4: return toBcd(eMo);
      5: return toBcd(eY);
      default: return eW;
    endcase
  endfunction

  task automatic modelAdvance();
    eS++;
    if (eS == 60) begin
      eS = 0; eM++;
      if (eM == 60) begin
        eM = 0; eH++;
        if (eH == 24) begin
          eH = 0; eW = (eW + 1) % 7; eD++;
          if (eD > daysIn(eMo, eY)) begin
            eD = 1; eMo++;
            if (eMo == 13) begin eMo = 1; eY = (eY + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(int a, int d);
    addr = 5'(a); wr_data = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic busRd(int a, output int d);
    addr = 5'(a);
    #1;
    d = int'(rd_data);
  endtask

  task automatic snap();
    busWr(13, runBit | 8'h40);
  endtask

  task automatic checkTime(string tag);
    int v;
    snap();
    for (int i = 0; i < 7; i++) begin
      busRd(i, v);
      chk(tag, v, expField(i));
    end
  endtask

  task automatic setRun(int r);
    runBit = r;
    busWr(13, r);
  endtask

  task automatic setTime(int s, int m, int h, int d, int mo, int y, int w);
    eS = s; eM = m; eH = h; eD = d; eMo = mo; eY = y; eW = w;
    for (int i = 0; i < 7; i++) busWr(i, expField(i));
  endtask

  task automatic doTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    matchSeen = int'(alarm_match);
    if (runBit != 0) modelAdvance();
  endtask

  task automatic setAlarm(int s, int m, int h, int d, int mo, int y);
    busWr(7, toBcd(s)); busWr(8, toBcd(m)); busWr(9, toBcd(h));
    busWr(10, toBcd(d)); busWr(11, toBcd(mo)); busWr(12, toBcd(y));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, old, n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    eS = 0; eM = 0; eH = 0; eD = 1; eMo = 1; eY = 0; eW = 0;
    for (int i = 0; i < 7; i++) begin
      busRd(i, v);
      chk("R1 reset time", v, expField(i));
    end
    busRd(13, v); chk("R1 reset ctrl", v, 0);
    chk("R1 reset alarm_match", int'(alarm_match), 0);

    // R2 storage and map
    for (int i = 7; i <= 12; i++) begin
      n = int'($urandom_range(0, 255));
      busWr(i, n); busRd(i, v); chk("R2 alarm readback", v, n);
    end
    busWr(13, 8'h3E); busRd(13, v); chk("R2 ctrl bits", v, 8'h3E);
    for (int i = 14; i <= 17; i++) begin
      n = int'($urandom_range(0, 255));
      busWr(i, n); busRd(i, v); chk("R2 misc readback", v, n);
    end
    busRd(18, v); chk("R2 unmapped", v, 0);
    busRd(31, v); chk("R2 unmapped top", v, 0);
    setRun(0);

    // R3 halted then running
    setTime(15, 30, 10, 12, 5, 21, 3);
    repeat (5) doTick();
    checkTime("R3 halted");
    setRun(1);
    repeat (3) doTick();
    checkTime("R3 running");

    // R4 stale copy persists, snap bit reads 0
    snap();
    busRd(0, old);
    doTick(); doTick();
    busRd(0, v); chk("R4 copy held", v, old);
    busRd(13, v); chk("R4 snap bit clear", v, 1);
    checkTime("R4 new capture");

    // R5 tick coinciding with a time write is lost
    setTime(30, 20, 10, 9, 9, 9, 2);
    addr = 5'd0; wr_data = 8'h45; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    eS = 45;
    checkTime("R5 write wins");

    // R6 second/minute/hour chain
    setTime(59, 59, 22, 10, 3, 10, 1);
    doTick(); checkTime("R6 hour carry");
    setTime(59, 59, 23, 10, 3, 10, 1);
    doTick(); checkTime("R6 midnight");

    // R7 month lengths
    setTime(59, 59, 23, 28, 2, 3, 4); doTick(); checkTime("R7 feb common");
    setTime(59, 59, 23, 28, 2, 4, 4); doTick(); checkTime("R7 feb leap 28");
    doTick(); checkTime("R7 feb leap 28 plus");
    setTime(59, 59, 23, 29, 2, 0, 5); doTick(); checkTime("R7 feb leap 29");
    setTime(59, 59, 23, 30, 4, 50, 0); doTick(); checkTime("R7 april");
    setTime(59, 59, 23, 30, 1, 50, 0); doTick(); checkTime("R7 jan 30");

    // R8 and R9 year end with weekday wrap
    setTime(59, 59, 23, 31, 12, 99, 6); doTick(); checkTime("R8 R9 century");
    setTime(59, 59, 23, 31, 12, 41, 2); doTick(); checkTime("R8 new year");

    // random sweep (R6 R7 R8 R9)
    for (int it = 0; it < 20; it++) begin
      int mo, y;
      mo = int'($urandom_range(1, 12));
      y  = int'($urandom_range(0, 99));
      setTime(int'($urandom_range(0, 59)), int'($urandom_range(0, 59)),
              int'($urandom_range(0, 23)), int'($urandom_range(1, daysIn(mo, y))),
              mo, y, int'($urandom_range(0, 6)));
      n = int'($urandom_range(1, 300));
      for (int k = 0; k < n; k++) doTick();
      checkTime("R6 R7 R8 R9 random");
    end
    setTime(59, 59, 23, 31, 12, 98, 0);
    for (int k = 0; k < 3; k++) doTick();
    checkTime("R8 random tail");

    // R10 alarm match
    setTime(58, 59, 23, 28, 2, 24, 5);
    setAlarm(59, 59, 23, 28, 2, 25);
    doTick(); chk("R10 partial match silent", matchSeen, 0);
    setTime(58, 59, 23, 28, 2, 24, 5);
    setAlarm(59, 59, 23, 28, 2, 24);
    doTick(); chk("R10 match pulse", matchSeen, 1);
    @(negedge clk); chk("R10 pulse one cycle", int'(alarm_match), 0);
    setAlarm(0, 0, 0, 29, 2, 24);
    busWr(6, 3); eW = 3;
    doTick(); chk("R10 rollover match ignores weekday", matchSeen, 1);
    doTick(); chk("R10 no repeat", matchSeen, 0);
    setRun(0);
    setTime(59, 59, 23, 28, 2, 24, 0);
    doTick(); chk("R10 halted no match", matchSeen, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule